// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a passive slave port through which an external host moves data to and from a processor core over an 8-bit bus. The host drives the chip select, the strobes, a byte-select line and a status-select line. The core sees a 16-bit input word written by the host, a 16-bit output word that the host reads, and an 8-bit control register.

Two flag pins report the state of the buffers. The full flag is set when the host has delivered a word. The empty flag is set when the host has taken the output word. The control register selects:
- 8-bit or 16-bit transfers;
- one of two strobe styles: separate read and write strobes, or one data strobe with a read/write line;
- the polarities of the byte select, the data strobe and the flag pins;
- whether both flags are merged onto one pin;
- whether the empty bit is inverted in the status byte.

All host lines pass through a two-stage synchroniser. A transfer completes when the strobe is released. The core receives a one-cycle interrupt pulse when a strobe is asserted, if the matching enable is set.

Top module: `hpi_port`

## Requirements
- R1: After reset the full flag is 0, the empty flag is 1 and the control register reads 0, so `pin_full` is 0 and `pin_empty` is 1.
- R2: While `h_cs_n` is high, strobe activity writes no data, changes no flag and raises no interrupt.
- R3: With control bit 0 clear (8-bit mode), only the low byte is reachable. Each completed low-byte write sets the full flag and each completed low-byte read sets the empty flag. The byte-select level that would address the high byte reaches nothing: writes there are dropped and reads there return 0.
- R4: Control bit 3 sets the byte-select polarity. When it is 0, `h_bsel` low addresses the low byte and `h_bsel` high addresses the high byte. When it is 1, the mapping is swapped.
- R5: With control bit 0 set (16-bit mode), the flag is updated only by the high-byte transfer when bit 3 is 0, and only by the low-byte transfer when bit 3 is 1.
- R6: A read with `h_stat` high and the low-byte select level returns the status byte. Bit 1 holds the full flag, bit 0 holds the empty flag and the upper bits are 0. A read with `h_stat` high and the other select level returns 0.
- R7: When control bit 1 is 0, `h_ids_n` is an active-low write strobe and `h_ods_n` is an active-low read strobe. When control bit 1 is 1, `h_ids_n` carries a data strobe and `h_ods_n` carries a read/write line (1 for read, 0 for write). The data strobe is active low when control bit 2 is 0 and active high when control bit 2 is 1.
- R8: Control bit 4 inverts both flag pins. When bit 4 is 0 the pins are active high.
- R9: When control bit 5 is set, `pin_full` carries the OR of both flags, active high.
- R10: Control bit 7 inverts the empty bit in the status byte only. It does not change `pin_empty`.
- R11: `irq_in` pulses for one cycle when a write strobe is asserted with chip select low and `irq_en_in` set. `irq_out` does the same for a read strobe when `irq_en_out` is set.
- R12: A host write latches its byte when the strobe is released. `ibuf_rd` clears the full flag. `obuf_wr` loads the output word and clears the empty flag.
- R13: A host read of the low or high byte returns the matching byte of the output word on `h_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ids_n | input | 1 | Write strobe, or data strobe in the single-strobe style |
| h_ods_n | input | 1 | Read strobe, or read/write line in the single-strobe style |
| h_bsel | input | 1 | Host byte select |
| h_stat | input | 1 | Host status select |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data |
| pin_full | output | 1 | Input-full flag pin |
| pin_empty | output | 1 | Output-empty flag pin |
| ctl_wr | input | 1 | Core control register write |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register value |
| ibuf_rd | input | 1 | Core reads the input word |
| ibuf_data | output | 16 | Input word assembled from host writes |
| obuf_wr | input | 1 | Core writes the output word |
| obuf_wdata | input | 16 | Output word value |
| irq_en_in | input | 1 | Enable for the write-strobe interrupt |
| irq_en_out | input | 1 | Enable for the read-strobe interrupt |
| irq_in | output | 1 | Write-strobe interrupt pulse |
| irq_out | output | 1 | Read-strobe interrupt pulse |

## Verification
The assertions check on every cycle:
- the reset state;
- that the interrupt pulses last one cycle and never follow a chip select that was high;
- the flag clears caused by core accesses;
- how the status byte, the merged pin and the empty pin relate to one another;
- the zero returned for the high byte in 8-bit mode.

Only the bench scenarios can show the behaviours that depend on a whole host transaction:
- which byte completes a 16-bit transfer under each byte-select polarity;
- that writes are dropped while chip select is high;
- that both strobe styles and both data-strobe polarities work;
- that each written byte lands in the correct half of the input word.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

    localparam int HOST_W = 8;

    // bit 7 down to bit 0 of the control register
    typedef struct packed {
        logic stat_empty_inv;
        logic rsvd;
        logic flag_merge;
        logic flag_pol;
        logic bsel_pol;
        logic ds_pol;
        logic one_strobe;
        logic wide;
    } ctl_t;

    typedef struct packed {
        logic cs_n;
        logic ids;
        logic ods;
        logic bsel;
        logic stat;
    } pins_t;

    localparam int PINS_W = $bits(pins_t);

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_STAT = 2'd3
    } tgt_e;

    function automatic tgt_e decode_tgt(input logic stat, input logic bsel, input ctl_t c);
        logic high_sel;
        high_sel = bsel ^ c.bsel_pol;
        if (stat)
            return high_sel ? TGT_NONE : TGT_STAT;
        if (!high_sel)
            return TGT_LO;
        return c.wide ? TGT_HI : TGT_NONE;
    endfunction

    function automatic logic is_final(input tgt_e t, input ctl_t c);
        if (!c.wide)
            return t == TGT_LO;
        return t == (c.bsel_pol ? TGT_LO : TGT_HI);
    endfunction

endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hpi_strobe.sv
module hpi_strobe
    import hpi_pkg::*;
#(
    parameter int HW = HOST_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pins_t         ps,
    input  logic [HW-1:0] din_s,
    input  ctl_t          ctl,
    output logic          wr_start,
    output logic          rd_start,
    output logic          wr_done,
    output logic          rd_done,
    output tgt_e          wr_tgt,
    output tgt_e          rd_tgt,
    output logic [HW-1:0] wr_byte
);
    logic       cs_on;
    logic       ds_on;
    logic [1:0] act;
    logic [1:0] start_v;
    logic [1:0] done_v;
    tgt_e [1:0] tgt_v;
    tgt_e       tgt_now;
    logic [HW-1:0] byte_q;

    always_comb begin
        cs_on   = ~ps.cs_n;
        ds_on   = ctl.ds_pol ? ps.ids : ~ps.ids;
        act[0]  = cs_on & (ctl.one_strobe ? (ds_on & ~ps.ods) : ~ps.ids);
        act[1]  = cs_on & (ctl.one_strobe ? (ds_on &  ps.ods) : ~ps.ods);
        tgt_now = decode_tgt(ps.stat, ps.bsel, ctl);
    end

    // index 0: host write direction, index 1: host read direction
    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic act_q;
        tgt_e tgt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                act_q <= 1'b0;
                tgt_q <= TGT_NONE;
            end else begin
                act_q <= act[d];
                if (act[d]) tgt_q <= tgt_now;
            end
        end
        assign start_v[d] = act[d] & ~act_q;
        assign done_v[d]  = act_q & ~act[d];
        assign tgt_v[d]   = tgt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         byte_q <= '0;
        else if (act[0]) byte_q <= din_s;
    end

    assign wr_start = start_v[0];
    assign rd_start = start_v[1];
    assign wr_done  = done_v[0];
    assign rd_done  = done_v[1];
    assign wr_tgt   = tgt_v[0];
    assign rd_tgt   = tgt_v[1];
    assign wr_byte  = byte_q;
endmodule

// File: rtl/hpi_bufs.sv
module hpi_bufs
    import hpi_pkg::*;
#(
    parameter int HW = HOST_W,
    localparam int WW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          ctl,
    input  logic          wr_done,
    input  tgt_e          wr_tgt,
    input  logic [HW-1:0] wr_byte,
    input  logic          rd_done,
    input  tgt_e          rd_tgt,
    input  logic          ibuf_rd,
    input  logic          obuf_wr,
    input  logic [WW-1:0] obuf_wdata,
    output logic [WW-1:0] ibuf,
    output logic [WW-1:0] obuf,
    output logic          full,
    output logic          empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ibuf  <= '0;
            obuf  <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            if (wr_done) begin
                if (wr_tgt == TGT_LO) ibuf[HW-1:0]  <= wr_byte;
                if (wr_tgt == TGT_HI) ibuf[WW-1:HW] <= wr_byte;
                if (is_final(wr_tgt, ctl)) full <= 1'b1;
            end
            if (ibuf_rd) full <= 1'b0;
            if (rd_done && is_final(rd_tgt, ctl)) empty <= 1'b1;
            if (obuf_wr) begin
                obuf  <= obuf_wdata;
                empty <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hpi_port.sv
module hpi_port
    import hpi_pkg::*;
#(
    parameter int HW     = HOST_W,
    parameter int SYNC_N = 2,
    localparam int WW    = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_cs_n,
    input  logic          h_ids_n,
    input  logic          h_ods_n,
    input  logic          h_bsel,
    input  logic          h_stat,
    input  logic [HW-1:0] h_din,
    output logic [HW-1:0] h_dout,
    output logic          pin_full,
    output logic          pin_empty,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    ctl_rdata,
    input  logic          ibuf_rd,
    output logic [WW-1:0] ibuf_data,
    input  logic          obuf_wr,
    input  logic [WW-1:0] obuf_wdata,
    input  logic          irq_en_in,
    input  logic          irq_en_out,
    output logic          irq_in,
    output logic          irq_out
);
    localparam int SW = PINS_W + HW;
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, ids: 1'b1, ods: 1'b1, bsel: 1'b0, stat: 1'b0};
    localparam logic [SW-1:0] SYNC_RST = {PINS_IDLE, {HW{1'b0}}};

    ctl_t          ctl_q;
    pins_t         ps;
    logic [HW-1:0] din_s;
    logic [SW-1:0] sync_q;
    logic          wr_start, rd_start, wr_done, rd_done;
    tgt_e          wr_tgt, rd_tgt, rd_sel;
    logic [HW-1:0] wr_byte;
    logic [WW-1:0] obuf;
    logic          full, empty;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_wr) begin
            ctl_q      <= ctl_t'(ctl_wdata);
            ctl_q.rsvd <= 1'b0;
        end
    end

    hpi_sync #(.W(SW), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({h_cs_n, h_ids_n, h_ods_n, h_bsel, h_stat, h_din}),
        .q   (sync_q)
    );
    assign ps    = pins_t'(sync_q[SW-1:HW]);
    assign din_s = sync_q[HW-1:0];

    hpi_strobe #(.HW(HW)) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .ps       (ps),
        .din_s    (din_s),
        .ctl      (ctl_q),
        .wr_start (wr_start),
        .rd_start (rd_start),
        .wr_done  (wr_done),
        .rd_done  (rd_done),
        .wr_tgt   (wr_tgt),
        .rd_tgt   (rd_tgt),
        .wr_byte  (wr_byte)
    );

    hpi_bufs #(.HW(HW)) u_bufs (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl_q),
        .wr_done    (wr_done),
        .wr_tgt     (wr_tgt),
        .wr_byte    (wr_byte),
        .rd_done    (rd_done),
        .rd_tgt     (rd_tgt),
        .ibuf_rd    (ibuf_rd),
        .obuf_wr    (obuf_wr),
        .obuf_wdata (obuf_wdata),
        .ibuf       (ibuf_data),
        .obuf       (obuf),
        .full       (full),
        .empty      (empty)
    );

    always_comb begin
        rd_sel = decode_tgt(h_stat, h_bsel, ctl_q);
        unique case (rd_sel)
            TGT_LO:   h_dout = obuf[HW-1:0];
            TGT_HI:   h_dout = obuf[WW-1:HW];
            TGT_STAT: h_dout = {{(HW-2){1'b0}}, full, empty ^ ctl_q.stat_empty_inv};
            default:  h_dout = '0;
        endcase
    end

    assign pin_empty = empty ^ ctl_q.flag_pol;
    assign pin_full  = ctl_q.flag_merge ? (full | empty) : (full ^ ctl_q.flag_pol);
    assign ctl_rdata = ctl_q;
    assign irq_in    = wr_start & irq_en_in;
    assign irq_out   = rd_start & irq_en_out;
endmodule

// File: rtl/hpi_port_chk.sv
module hpi_port_chk #(
    parameter int HW = 8,
    localparam int WW = 2 * HW
) (
    input logic          clk,
    input logic          rst,
    input logic          h_cs_n,
    input logic          h_bsel,
    input logic          h_stat,
    input logic [HW-1:0] h_dout,
    input logic          pin_full,
    input logic          pin_empty,
    input logic          ctl_wr,
    input logic [7:0]    ctl_rdata,
    input logic          ibuf_rd,
    input logic          obuf_wr,
    input logic          irq_in,
    input logic          irq_out
);
    logic stat_sel;
    assign stat_sel = h_stat && !(h_bsel ^ ctl_rdata[3]);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctl_rdata == 8'h00 && pin_empty && !pin_full));

    // R11
    irq_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_in |=> !irq_in);

    // R11
    irq_out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |=> !irq_out);

    // R2
    irq_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_in || irq_out) |-> !$past(h_cs_n, 2));

    // R12
    empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (obuf_wr && !ctl_wr) |=> (pin_empty == ctl_rdata[4]));

    // R12
    full_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ibuf_rd && !ctl_wr && !ctl_rdata[5]) |=> (pin_full == ctl_rdata[4]));

    // R6
    stat_upper_chk: assert property (@(posedge clk) disable iff (rst)
        stat_sel |-> (h_dout[HW-1:2] == '0));

    // R10
    stat_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_sel && !ctl_rdata[4]) |-> (h_dout[0] == (pin_empty ^ ctl_rdata[7])));

    // R9
    merge_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_sel && ctl_rdata[5]) |-> (pin_full == (h_dout[1] | (h_dout[0] ^ ctl_rdata[7]))));

    // R3
    narrow_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_rdata[0] && !h_stat && (h_bsel ^ ctl_rdata[3])) |-> (h_dout == '0));
endmodule

bind hpi_port hpi_port_chk #(.HW(HW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .h_cs_n    (h_cs_n),
    .h_bsel    (h_bsel),
    .h_stat    (h_stat),
    .h_dout    (h_dout),
    .pin_full  (pin_full),
    .pin_empty (pin_empty),
    .ctl_wr    (ctl_wr),
    .ctl_rdata (ctl_rdata),
    .ibuf_rd   (ibuf_rd),
    .obuf_wr   (obuf_wr),
    .irq_in    (irq_in),
    .irq_out   (irq_out)
);

// File: tb/hpi_port_bench.sv
module hpi_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_cs_n = 1'b1, h_ids_n = 1'b1, h_ods_n = 1'b1;
    logic        h_bsel = 1'b0, h_stat = 1'b0;
    logic [7:0]  h_din = 8'h00;
    logic [7:0]  h_dout;
    logic        pin_full, pin_empty;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_rdata;
    logic        ibuf_rd = 1'b0;
    logic [15:0] ibuf_data;
    logic        obuf_wr = 1'b0;
    logic [15:0] obuf_wdata = 16'h0000;
    logic        irq_en_in = 1'b0, irq_en_out = 1'b0;
    logic        irq_in, irq_out;

    always #10 clk = ~clk;

    hpi_port u_hpi_port (
        .clk(clk), .rst(rst), .h_cs_n(h_cs_n), .h_ids_n(h_ids_n), .h_ods_n(h_ods_n),
        .h_bsel(h_bsel), .h_stat(h_stat), .h_din(h_din), .h_dout(h_dout),
        .pin_full(pin_full), .pin_empty(pin_empty), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .ibuf_rd(ibuf_rd),
        .ibuf_data(ibuf_data), .obuf_wr(obuf_wr), .obuf_wdata(obuf_wdata),
        .irq_en_in(irq_en_in), .irq_en_out(irq_en_out), .irq_in(irq_in), .irq_out(irq_out)
    );

    // reference model state
    logic [7:0]  m_ctl = 8'h00;
    logic        m_full = 1'b0, m_empty = 1'b1;
    logic [15:0] m_ibuf = 16'h0, m_obuf = 16'h0;
    bit          busy = 1'b1;
    bit          done = 1'b0;
    int          n_tests = 0, n_fail = 0;
    int          irq_in_cnt = 0, irq_out_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic m_pin_full();
        if (m_ctl[5]) return m_full | m_empty;
        return m_full ^ m_ctl[4];
    endfunction

    function automatic logic m_pin_empty();
        return m_empty ^ m_ctl[4];
    endfunction

    // 0 none, 1 low byte, 2 high byte, 3 status
    function automatic int m_tgt(input logic stat, input logic bsel);
        logic hi;
        hi = bsel ^ m_ctl[3];
        if (stat) return hi ? 0 : 3;
        if (!hi) return 1;
        return m_ctl[0] ? 2 : 0;
    endfunction

    function automatic bit m_last(input int t);
        if (!m_ctl[0]) return t == 1;
        return t == (m_ctl[3] ? 1 : 2);
    endfunction

    function automatic logic [7:0] m_read(input int t);
        case (t)
            1: return m_obuf[7:0];
            2: return m_obuf[15:8];
            3: return {6'b0, m_full, m_empty ^ m_ctl[7]};
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge clk) begin
        if (irq_in)  irq_in_cnt++;
        if (irq_out) irq_out_cnt++;
        if (!rst && !busy && !done) begin
            chk("R12 per-cycle pin_full", pin_full, m_pin_full());
            chk("R12 per-cycle pin_empty", pin_empty, m_pin_empty());
            chk("R12 per-cycle ibuf_data", ibuf_data, m_ibuf);
            chk("R1 per-cycle ctl_rdata", ctl_rdata, m_ctl);
        end
    end

    task automatic idle_pins();
        h_cs_n = 1'b1; h_stat = 1'b0; h_bsel = 1'b0; h_ods_n = 1'b1;
        h_ids_n = (m_ctl[1] && m_ctl[2]) ? 1'b0 : 1'b1;
    endtask

    task automatic drive_strobe(input bit wr, input bit on);
        if (!m_ctl[1]) begin
            if (wr) h_ids_n = ~on; else h_ods_n = ~on;
        end else begin
            h_ods_n = ~wr;
            h_ids_n = m_ctl[2] ? on : ~on;
        end
    endtask

    task automatic set_ctl(input logic [7:0] v);
        busy = 1'b1;
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
        m_ctl = v & 8'hBF;
        idle_pins();
        @(negedge clk); busy = 1'b0;
    endtask

    task automatic core_rd();
        busy = 1'b1;
        @(negedge clk); ibuf_rd = 1'b1;
        @(negedge clk); ibuf_rd = 1'b0; m_full = 1'b0;
        @(negedge clk); busy = 1'b0;
    endtask

    task automatic core_wr(input logic [15:0] v);
        busy = 1'b1;
        @(negedge clk); obuf_wr = 1'b1; obuf_wdata = v;
        @(negedge clk); obuf_wr = 1'b0; m_obuf = v; m_empty = 1'b0;
        @(negedge clk); busy = 1'b0;
    endtask

    task automatic host_xfer(input bit wr, input bit cs_en, input logic bsel, input logic stat,
                             input logic [7:0] d, output logic [7:0] rd);
        int t;
        busy = 1'b1;
        @(negedge clk);
        h_cs_n = ~cs_en; h_bsel = bsel; h_stat = stat; h_din = d;
        drive_strobe(wr, 1'b0);
        @(negedge clk); drive_strobe(wr, 1'b1);
        repeat (3) @(negedge clk);
        rd = h_dout;
        drive_strobe(wr, 1'b0);
        repeat (5) @(negedge clk);
        idle_pins();
        if (cs_en) begin
            t = m_tgt(stat, bsel);
            if (wr) begin
                if (t == 1) m_ibuf[7:0]  = d;
                if (t == 2) m_ibuf[15:8] = d;
                if (m_last(t)) m_full = 1'b1;
            end else if (m_last(t)) begin
                m_empty = 1'b1;
            end
        end
        @(negedge clk); busy = 1'b0;
    endtask

    task automatic host_wr(input bit cs_en, input logic bsel, input logic stat, input logic [7:0] d);
        logic [7:0] dummy;
        host_xfer(1'b1, cs_en, bsel, stat, d, dummy);
    endtask

    task automatic host_rd_chk(input string req, input logic bsel, input logic stat);
        logic [7:0] got, exp;
        exp = m_read(m_tgt(stat, bsel));
        host_xfer(1'b0, 1'b1, bsel, stat, 8'h00, got);
        chk(req, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 pin_full", pin_full, 1'b0);
        chk("R1 pin_empty", pin_empty, 1'b1);
        chk("R1 ctl", ctl_rdata, 8'h00);
        busy = 1'b0;

        // R3 and R13: 8-bit mode
        core_wr(16'hA55A);
        chk("R12 empty cleared", pin_empty, 1'b0);
        host_rd_chk("R13 8-bit low read", 1'b0, 1'b0);
        chk("R3 empty set by low read", pin_empty, 1'b1);
        host_wr(1'b1, 1'b0, 1'b0, 8'h3C);
        chk("R3 full set by low write", pin_full, 1'b1);
        chk("R12 low byte latched", ibuf_data, 16'h003C);
        host_rd_chk("R6 status byte", 1'b0, 1'b1);
        host_rd_chk("R6 reserved status combo", 1'b1, 1'b1);
        core_rd();
        chk("R12 full cleared", pin_full, 1'b0);
        host_wr(1'b1, 1'b1, 1'b0, 8'h77);
        chk("R3 high write ignored", ibuf_data, 16'h003C);
        chk("R3 high write no flag", pin_full, 1'b0);
        host_rd_chk("R3 high read returns zero", 1'b1, 1'b0);

        // R2: chip select high
        irq_en_in = 1'b1;
        c0 = irq_in_cnt;
        host_wr(1'b0, 1'b0, 1'b0, 8'hEE);
        chk("R2 data ignored", ibuf_data, 16'h003C);
        chk("R2 no flag", pin_full, 1'b0);
        chk("R2 no irq", irq_in_cnt - c0, 0);

        // R11
        c0 = irq_in_cnt;
        host_wr(1'b1, 1'b0, 1'b0, 8'h12);
        chk("R11 irq_in once", irq_in_cnt - c0, 1);
        core_rd();
        irq_en_in = 1'b0;
        c0 = irq_in_cnt;
        host_wr(1'b1, 1'b0, 1'b0, 8'h13);
        chk("R11 irq_in disabled", irq_in_cnt - c0, 0);
        core_rd();

        // R5 and R4: 16-bit, polarity 0
        set_ctl(8'h01);
        host_wr(1'b1, 1'b0, 1'b0, 8'h11);
        chk("R5 low byte no flag", pin_full, 1'b0);
        host_wr(1'b1, 1'b1, 1'b0, 8'h22);
        chk("R5 high byte sets full", pin_full, 1'b1);
        chk("R4 word assembled", ibuf_data, 16'h2211);
        core_rd();
        core_wr(16'hBEEF);
        irq_en_out = 1'b1;
        c0 = irq_out_cnt;
        host_rd_chk("R13 16-bit low", 1'b0, 1'b0);
        chk("R11 irq_out once", irq_out_cnt - c0, 1);
        irq_en_out = 1'b0;
        chk("R5 low read keeps empty clear", pin_empty, 1'b0);
        host_rd_chk("R13 16-bit high", 1'b1, 1'b0);
        chk("R5 high read sets empty", pin_empty, 1'b1);

        // R4 and R5: 16-bit, polarity 1
        set_ctl(8'h09);
        host_wr(1'b1, 1'b0, 1'b0, 8'h44);
        chk("R5 swapped high no flag", pin_full, 1'b0);
        host_wr(1'b1, 1'b1, 1'b0, 8'h33);
        chk("R5 swapped low sets full", pin_full, 1'b1);
        chk("R4 swapped word", ibuf_data, 16'h4433);
        host_rd_chk("R6 status with swapped select", 1'b1, 1'b1);
        core_rd();

        // R8 polarity, R9 merge, R10 status inversion
        set_ctl(8'h10);
        chk("R8 inverted full pin", pin_full, 1'b1);
        chk("R8 inverted empty pin", pin_empty, 1'b0);
        set_ctl(8'h20);
        chk("R9 merged pin", pin_full, 1'b1);
        set_ctl(8'h80);
        chk("R10 empty pin unchanged", pin_empty, 1'b1);
        host_rd_chk("R10 status empty inverted", 1'b0, 1'b1);

        // R7: single strobe, active low then active high
        set_ctl(8'h02);
        core_wr(16'h0055);
        host_wr(1'b1, 1'b0, 1'b0, 8'h9A);
        chk("R7 ds low write", ibuf_data, 16'h449A);
        chk("R7 ds low full", pin_full, 1'b1);
        host_rd_chk("R7 ds low read", 1'b0, 1'b0);
        chk("R7 ds low empty", pin_empty, 1'b1);
        core_rd();
        set_ctl(8'h06);
        core_wr(16'h00C3);
        host_wr(1'b1, 1'b0, 1'b0, 8'h5B);
        chk("R7 ds high write", ibuf_data, 16'h445B);
        host_rd_chk("R7 ds high read", 1'b0, 1'b0);
        chk("R7 ds high empty", pin_empty, 1'b1);
        core_rd();

        done = 1'b1;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule